// File: doc/BRIEF.md
# Daisy-chain switch write master

This block is the host side of a serial link to a string of identical 8-bit switch controllers connected in series: the master's data line feeds the first device, each device's serial output feeds the next, and the last device's output comes back to the master. One request writes a whole frame. Each frame carries one byte for every device in the string, inside a single active-low frame-select window. The serial clock is gated, so only the exact burst of 8×NDEV pulses is produced. Frame select is raised only after the last pulse, so every device latches its own byte at the same moment.

A user presents all NDEV bytes in parallel on `wr_data` and pulses `start`. `busy` then stays high until the frame and a closing idle gap are over, and `done` pulses for one cycle. The bits that the string shifts back during the frame are the bytes the devices held before the write. They appear on `rd_data` together with `done`. The serial clock rate is set by a parameter, DIV, which is the number of system clock cycles in each half period of the serial clock.

Top module: `chain_switch_writer`

## Requirements
- R1: While `rst_n` is low and after its release, `sel_n`=1, `sclk`=1, `busy`=0, `done`=0 and `rd_data`=0.
- R2: `start` sampled high while idle drives `sel_n` low and `busy` high at that same clock edge. The first falling edge of `sclk` follows 2×DIV cycles later.
- R3: Each frame contains exactly 8×NDEV falling edges of `sclk`. `sclk` is high whenever `sel_n` is high.
- R4: Device k, with k=0 the device next to the master, receives `wr_data[8k+7:8k]`. The frame sends `wr_data` from bit 8×NDEV-1 down to bit 0, so the farthest device's byte goes first and each byte goes most significant bit first.
- R5: `mosi` changes only at the clock edge where `sclk` rises or `sel_n` falls, so it is steady across every falling edge. Each `sclk` level lasts DIV cycles.
- R6: `sel_n` rises DIV cycles after the last rising edge of `sclk`.
- R7: `busy` falls and `done` pulses for exactly one cycle GAP cycles after `sel_n` rises. From the edge that accepts `start` to `done`, a frame takes DIV×(16×NDEV+2)+GAP cycles.
- R8: `sdi` is sampled at each edge where `sclk` falls. The first bit that arrives ends up in `rd_data[8×NDEV-1]`, and later bits fill the lower positions in the order they arrive. `rd_data` changes only in the cycle in which `done` is high.
- R9: `start` while `busy` is high is ignored: no second frame, no extra `done`, and the frame in progress keeps the data that was loaded at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one frame; taken only while idle |
| wr_data | input | 8×NDEV | Byte k goes to device k (0 = next to the master) |
| sdi | input | 1 | Serial data returned by the far end of the string |
| busy | output | 1 | Frame or closing gap in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| rd_data | output | 8×NDEV | Bits shifted back during the last frame, first arrival at the top |
| sel_n | output | 1 | Frame select, active low |
| sclk | output | 1 | Gated serial clock, idles high |
| mosi | output | 1 | Serial data to the first device |

## Verification
Every result has a fixed due cycle, counted in system clock edges from the edge that accepts `start`. Frame select falls at offset 0 and the first serial clock fall at 2×DIV. The final rising edge is followed by frame select rising DIV cycles later, and `done` comes GAP cycles after that, for DIV×(16×NDEV+2)+GAP in total. The bench stamps each of these events with a running edge count taken on the falling system clock edge, and compares the differences against those offsets. It also checks every bit on `mosi` as the serial clock falls, and checks the latched bytes and `rd_data` in the cycle where `done` is high.

// File: rtl/csw_pkg.sv
package csw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } csw_state_e;

  // serial bits in one frame
  function automatic int unsigned frame_bits(input int unsigned ndev);
    return 8 * ndev;
  endfunction

  // cycles from the edge that accepts start to the edge that raises done
  function automatic int unsigned frame_latency(input int unsigned ndev,
                                                input int unsigned div,
                                                input int unsigned gap);
    return div * (2 * frame_bits(ndev) + 2) + gap;
  endfunction

endpackage

// File: rtl/csw_tick.sv
module csw_tick #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!en || tick)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/csw_shift.sv
module csw_shift #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tx_adv,
  input  logic         rx_cap,
  input  logic         rx_bit,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;

  assign mosi    = tx_q[W-1];
  assign rx_word = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load) begin
      tx_q <= load_val;
      rx_q <= '0;
    end else begin
      if (tx_adv) tx_q <= {tx_q[W-2:0], 1'b0};
      if (rx_cap) rx_q <= {rx_q[W-2:0], rx_bit};
    end
  end
endmodule

// File: rtl/chain_switch_writer.sv
module chain_switch_writer
  import csw_pkg::*;
#(
  parameter int unsigned NDEV = 3,
  parameter int unsigned DIV  = 2,
  parameter int unsigned GAP  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [8*NDEV-1:0]         wr_data,
  input  logic                      sdi,
  output logic                      busy,
  output logic                      done,
  output logic [8*NDEV-1:0]         rd_data,
  output logic                      sel_n,
  output logic                      sclk,
  output logic                      mosi
);
  localparam int unsigned TOTAL = frame_bits(NDEV);
  localparam int unsigned BW    = $clog2(TOTAL + 1);
  localparam int unsigned GW    = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(TOTAL - 1);
  localparam logic [GW-1:0] LAST_GAP = GW'(GAP - 1);

  csw_state_e        state;
  logic [BW-1:0]     bit_cnt;
  logic [GW-1:0]     gap_cnt;
  logic              sel_q, sclk_q, done_q;
  logic [TOTAL-1:0]  rd_q;
  logic [TOTAL-1:0]  rx_word;

  // named internal events
  logic tick, frame_go, fall_ev, rise_ev, last_rise, gap_end;

  assign frame_go  = start && (state == ST_IDLE);
  assign fall_ev   = (state == ST_SHIFT) && tick && sclk_q;
  assign rise_ev   = (state == ST_SHIFT) && tick && !sclk_q;
  assign last_rise = rise_ev && (bit_cnt == LAST_BIT);
  assign gap_end   = (state == ST_GAP) && (gap_cnt == LAST_GAP);

  assign busy    = (state != ST_IDLE);
  assign done    = done_q;
  assign rd_data = rd_q;
  assign sel_n   = sel_q;
  assign sclk    = sclk_q;

  csw_tick #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (busy),
    .tick  (tick)
  );

  csw_shift #(.W(TOTAL)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_go),
    .load_val (wr_data),
    .tx_adv   (rise_ev && !last_rise),
    .rx_cap   (fall_ev),
    .rx_bit   (sdi),
    .mosi     (mosi),
    .rx_word  (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sel_q   <= 1'b1;
      sclk_q  <= 1'b1;
      bit_cnt <= '0;
      gap_cnt <= '0;
      done_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (frame_go) begin
          state   <= ST_LEAD;
          sel_q   <= 1'b0;
          bit_cnt <= '0;
        end
        ST_LEAD: if (tick) state <= ST_SHIFT;
        ST_SHIFT: begin
          if (fall_ev) begin
            sclk_q <= 1'b0;
          end else if (rise_ev) begin
            sclk_q  <= 1'b1;
            bit_cnt <= bit_cnt + 1'b1;
            if (last_rise) state <= ST_TRAIL;
          end
        end
        ST_TRAIL: if (tick) begin
          sel_q   <= 1'b1;
          gap_cnt <= '0;
          state   <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_end) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
            rd_q   <= rx_word;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csw_checker.sv
module csw_checker #(
  parameter int unsigned NDEV = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [8*NDEV-1:0] rd_data,
  input logic              sel_n,
  input logic              sclk,
  input logic              mosi,
  input logic              tick,
  input logic              frame_go
);
  localparam int unsigned TOTAL = 8 * NDEV;
  localparam int unsigned FW    = $clog2(TOTAL + 2);

  logic [FW-1:0] fall_cnt;
  logic          sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_cnt  <= '0;
      sclk_prev <= 1'b1;
    end else begin
      sclk_prev <= sclk;
      if (sel_n && !busy)               fall_cnt <= '0;
      else if (!sel_n && sclk_prev && !sclk) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  assert_sclk_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> sclk);

  assert_fall_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |-> (fall_cnt == FW'(TOTAL)));

  assert_frame_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |=> (!sel_n && busy));

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> !$past(busy));

  assert_mosi_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> ($rose(sclk) || $fell(sel_n)));

  assert_sclk_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> $past(tick));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && sel_n));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_data));
endmodule

bind chain_switch_writer csw_checker #(.NDEV(NDEV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .rd_data  (rd_data),
  .sel_n    (sel_n),
  .sclk     (sclk),
  .mosi     (mosi),
  .tick     (tick),
  .frame_go (frame_go)
);

// File: tb/sim_chain_switch_writer.sv
module sim_chain_switch_writer;
  localparam int unsigned NDEV = 3;
  localparam int unsigned DIV  = 2;
  localparam int unsigned GAP  = 4;
  localparam int unsigned TOT  = 8 * NDEV;
  localparam int CLK_PERIOD    = 10;
  // half periods: lead-in, two per bit, trailing hold; then the gap
  localparam int LATENCY = DIV + DIV * TOT * 2 + DIV + GAP;

  logic clk = 1'b0;
  logic rst_n, start, sdi;
  logic [TOT-1:0] wr_data;
  logic busy, done, sel_n, sclk, mosi;
  logic [TOT-1:0] rd_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  chain_switch_writer #(.NDEV(NDEV), .DIV(DIV), .GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_data(wr_data), .sdi(sdi),
    .busy(busy), .done(done), .rd_data(rd_data), .sel_n(sel_n),
    .sclk(sclk), .mosi(mosi)
  );

  // string of devices: device 0 is the low byte, next to the master
  logic [TOT-1:0] chain_sr  = '0;
  logic [TOT-1:0] chain_lat = '0;
  assign sdi = chain_sr[TOT-1];
  always @(negedge sclk) if (!sel_n) chain_sr <= {chain_sr[TOT-2:0], mosi};
  always @(posedge sel_n) chain_lat <= chain_sr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_cnt = 0;
  always @(posedge clk) cyc++;

  typedef struct {
    logic [TOT-1:0] wr;
    logic [TOT-1:0] rd;
    int             t0;
  } item_t;
  item_t q[$];
  logic [TOT-1:0] prev_wr = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: pushes the expected outcome, then requests the frame
  task automatic send(input logic [TOT-1:0] w, input int extra_at);
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    q.push_back('{wr: w, rd: prev_wr, t0: cyc + 1});
    prev_wr = w;
    wr_data = w;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra_at > 0) begin
      repeat (extra_at) @(negedge clk);
      wr_data = ~w;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  // monitor
  logic prev_sel = 1'b1, prev_sclk = 1'b1, prev_done = 1'b0;
  logic [TOT-1:0] last_rd = '0;
  int nfall = 0, t_lr = 0, t_sr = 0;
  bit have_ff = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!sel_n && prev_sel) begin
        nfall = 0;
        have_ff = 0;
        chk(q.size() > 0, "R9 frame without request", 64'(q.size()), 64'd1);
        if (q.size() > 0)
          chk(cyc == q[0].t0 && busy, "R2 sel_n fall edge", 64'(cyc), 64'(q[0].t0));
      end
      if (!sclk && prev_sclk && !sel_n && q.size() > 0) begin
        if (!have_ff) begin
          chk(cyc - q[0].t0 == 2 * DIV, "R2 first sclk fall", 64'(cyc - q[0].t0), 64'(2 * DIV));
          have_ff = 1;
        end
        if (nfall < TOT)
          chk(mosi == q[0].wr[TOT-1-nfall], "R4 R5 bit on mosi", 64'(mosi),
              64'(q[0].wr[TOT-1-nfall]));
        nfall++;
      end
      if (sclk && !prev_sclk && !sel_n) t_lr = cyc;
      if (sel_n && !prev_sel) begin
        t_sr = cyc;
        chk(cyc - t_lr == DIV, "R6 sel_n rise after last rise", 64'(cyc - t_lr), 64'(DIV));
        chk(nfall == TOT, "R3 falling edge count", 64'(nfall), 64'(TOT));
        chk(sclk == 1'b1, "R3 sclk high at frame end", 64'(sclk), 64'd1);
        chk(rd_data == last_rd, "R8 rd_data held in frame", 64'(rd_data), 64'(last_rd));
      end
      if (done) begin
        done_cnt++;
        chk(!prev_done, "R7 done one cycle", 64'(prev_done), 64'd0);
        if (q.size() == 0) begin
          chk(1'b0, "R9 extra done", 64'd1, 64'd0);
        end else begin
          chk(cyc - t_sr == GAP, "R7 gap before done", 64'(cyc - t_sr), 64'(GAP));
          chk(cyc - q[0].t0 == LATENCY, "R7 frame latency", 64'(cyc - q[0].t0), 64'(LATENCY));
          chk(!busy, "R7 busy low with done", 64'(busy), 64'd0);
          chk(chain_lat == q[0].wr, "R4 device bytes", 64'(chain_lat), 64'(q[0].wr));
          chk(rd_data == q[0].rd, "R8 readback", 64'(rd_data), 64'(q[0].rd));
          void'(q.pop_front());
        end
        last_rd = rd_data;
      end
      prev_sel  = sel_n;
      prev_sclk = sclk;
      prev_done = done;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    wr_data = '0;
    repeat (2) @(negedge clk);
    chk(sel_n && sclk && !busy && !done && rd_data == '0, "R1 in reset",
        {sel_n, sclk, busy, done}, 4'b1100);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_n == 1'b1, "R1 sel_n", 64'(sel_n), 64'd1);
    chk(sclk == 1'b1, "R1 sclk", 64'(sclk), 64'd1);
    chk(!busy && !done, "R1 busy/done", {busy, done}, 64'd0);
    chk(rd_data == '0, "R1 rd_data", 64'(rd_data), 64'd0);

    send(24'hA53C81, 0);
    send(24'hFFFFFF, 0);
    send(24'h000000, 0);
    send(24'h5A0001, 0);
    send(24'h3C96E1, 10);   // R9: second start mid-frame
    send(24'h7E8001, 0);
    repeat (30) @(negedge clk);
    chk(q.size() == 0, "R9 queue drained", 64'(q.size()), 64'd0);
    chk(done_cnt == 6, "R9 done count", 64'(done_cnt), 64'd6);
    chk(!busy && sel_n, "R9 idle after ignored start", {busy, sel_n}, 64'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule